// File: doc/BRIEF.md
# SMBus Address Match Snooper

This block listens to a two-wire SMBus segment without ever driving it. It synchronises the clock and data lines to the system clock and finds start and stop conditions. From those it follows the phases of each transfer: the address, the direction bit, the data bytes and the acknowledges. It does this for every transfer on the wire, including those that the local host controller starts itself. Two programmable 7-bit addresses are compared against the address byte of each transfer.

The host-slave address matches only when the transfer is a write. The snoop address matches in either direction. A match is not reported when the address is seen. It is held pending until the acknowledge of the last byte has finished, which is recognised by a stop or by a repeated start. At that point the match is reported as a single-cycle pulse. If the clock line is held low for longer than the timeout limit, the block discards any pending match, raises a timeout pulse, drops its bus-busy level and waits for a new start.

The outputs are meant for an interrupt or status stage that sits next to this block.

Top module: `smbus_snooper`

## Requirements
- R1: `host_match_o` pulses only when the address byte carries `host_addr_i` in its upper seven bits (sent MSB first) and its least significant bit (the direction bit) is 0, meaning write.
- R2: `snoop_match_o` pulses when the upper seven bits of the address byte equal `snoop_addr_i`, whatever the value of the direction bit.
- R3: Each match pulse lasts exactly one clock. It is issued only when a stop or a repeated start follows a finished acknowledge bit, and never at address time.
- R4: A clock-low timeout that occurs after the address has matched but before the closing acknowledge cancels the match, so no pulse is issued.
- R5: `timeout_o` pulses once, for one clock, when the synchronised clock line has been low for `TMO_CYCLES` clocks. The count restarts whenever the clock line is high.
- R6: `bus_busy_o` is high from a start condition until the following stop condition.
- R7: A timeout clears `bus_busy_o`. After a timeout, clock pulses and stops are ignored until the next start.
- R8: Every start, including a repeated start in the middle of a byte, resets the bit and byte tracking, so the next eight bits are taken as the address byte.
- R9: After reset, `host_match_o`, `snoop_match_o`, `timeout_o` and `bus_busy_o` are all low.
- R10: A stop that arrives in the middle of a byte, before any acknowledge has finished since the last completed byte, produces no match pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| host_addr_i | input | 7 | Host-as-slave address, matched on writes only |
| snoop_addr_i | input | 7 | Snoop address, matched in either direction |
| host_match_o | output | 1 | One-cycle pulse for a committed host-slave match |
| snoop_match_o | output | 1 | One-cycle pulse for a committed snoop match |
| bus_busy_o | output | 1 | High while a transfer is in progress |
| timeout_o | output | 1 | One-cycle pulse when the clock-low limit is reached |

## Verification
Suppose the bit counter becomes misaligned, for example because a start failed to reset it. The comparison then uses a shifted address, and the result shows up as a missing or extra match pulse within a few clocks of the next stop. If the pending flags or the acknowledge-finished flag are wrong, the error appears at the stop or repeated start as a pulse on the wrong output, or as a pulse after a timeout. If the state is stuck, `bus_busy_o` holds the wrong level during the bit phases that immediately follow a start, a stop or a timeout.

// File: rtl/snp_pkg.sv
package snp_pkg;
  localparam int unsigned BIT_CNT_W = 4;
  localparam int unsigned ACK_IDX   = 9;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } snp_state_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
    logic scl_fall;
  } bus_evt_t;
endpackage

// File: rtl/snp_sync.sv
module snp_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar w = 0; w < WIDTH; w++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;  // idle bus reads high
      else         chain_q <= {chain_q[STAGES-2:0], d_i[w]};
    end
    assign q_o[w] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/snp_bus_cond.sv
module snp_bus_cond
  import snp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     scl_i,
  input  logic     sda_i,
  output bus_evt_t evt_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    evt_o.start    = scl_i & scl_q & sda_q & ~sda_i;
    evt_o.stop     = scl_i & scl_q & ~sda_q & sda_i;
    evt_o.scl_rise = scl_i & ~scl_q;
    evt_o.scl_fall = ~scl_i & scl_q;
  end
endmodule

// File: rtl/snp_tmo.sv
module snp_tmo #(
  parameter int unsigned TMO_CYCLES = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic tmo_o
);
  localparam int unsigned CNT_W = $clog2(TMO_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic             fire;

  // Counter parks at LIMIT so one low period fires once
  assign fire = ~scl_i & (cnt_q == LIMIT - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_o <= 1'b0;
    end else begin
      tmo_o <= fire;
      if (scl_i)               cnt_q <= '0;
      else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/snp_frame.sv
module snp_frame
  import snp_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bus_evt_t          evt_i,
  input  logic              sda_i,
  input  logic              tmo_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              host_match_o,
  output logic              snoop_match_o,
  output logic              busy_o
);
  localparam int unsigned SHIFT_W = ADDR_W + 1;
  localparam logic [BIT_CNT_W-1:0] DIR_IDX = BIT_CNT_W'(ADDR_W);
  localparam logic [BIT_CNT_W-1:0] ACK_CNT = BIT_CNT_W'(ACK_IDX);

  snp_state_e           state_q;
  logic [BIT_CNT_W-1:0] cnt_q;
  logic [SHIFT_W-1:0]   shift_q;
  logic                 first_q, ack_done_q;
  logic                 pend_host_q, pend_snoop_q;
  logic                 active, commit, addr_bit;
  logic                 hit_host, hit_snoop;

  assign active   = (state_q == ST_ACTIVE);
  assign commit   = active & ack_done_q & (evt_i.start | evt_i.stop) & ~tmo_i;
  assign addr_bit = active & first_q & evt_i.scl_rise & (cnt_q == DIR_IDX);
  assign hit_host  = (shift_q[ADDR_W-1:0] == host_addr_i) & ~sda_i;
  assign hit_snoop = (shift_q[ADDR_W-1:0] == snoop_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_match_o  <= 1'b0;
      snoop_match_o <= 1'b0;
    end else begin
      host_match_o  <= commit & pend_host_q;
      snoop_match_o <= commit & pend_snoop_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      shift_q      <= '0;
      first_q      <= 1'b0;
      ack_done_q   <= 1'b0;
      pend_host_q  <= 1'b0;
      pend_snoop_q <= 1'b0;
    end else if (tmo_i) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      first_q      <= 1'b0;
      ack_done_q   <= 1'b0;
      pend_host_q  <= 1'b0;
      pend_snoop_q <= 1'b0;
    end else if (evt_i.start) begin
      state_q      <= ST_ACTIVE;
      cnt_q        <= '0;
      first_q      <= 1'b1;
      ack_done_q   <= 1'b0;
      pend_host_q  <= 1'b0;
      pend_snoop_q <= 1'b0;
    end else if (evt_i.stop) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      first_q      <= 1'b0;
      ack_done_q   <= 1'b0;
      pend_host_q  <= 1'b0;
      pend_snoop_q <= 1'b0;
    end else if (active) begin
      if (evt_i.scl_rise) begin
        if (cnt_q != ACK_CNT) cnt_q <= cnt_q + 1'b1;
        if (cnt_q < ACK_CNT - 1'b1) shift_q <= {shift_q[SHIFT_W-2:0], sda_i};
        if (addr_bit) begin
          pend_host_q  <= hit_host;
          pend_snoop_q <= hit_snoop;
        end
      end
      if (evt_i.scl_fall) begin
        if (cnt_q == ACK_CNT) begin
          cnt_q      <= '0;
          first_q    <= 1'b0;
          ack_done_q <= 1'b1;
        end else begin
          ack_done_q <= 1'b0;
        end
      end
    end
  end

  assign busy_o = active;
endmodule

// File: rtl/smbus_snooper.sv
module smbus_snooper
  import snp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TMO_CYCLES  = 2_500_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              host_match_o,
  output logic              snoop_match_o,
  output logic              bus_busy_o,
  output logic              timeout_o
);
  logic [1:0] line_s;
  bus_evt_t   evt;

  snp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );

  snp_bus_cond u_cond (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (line_s[1]),
    .sda_i (line_s[0]),
    .evt_o (evt)
  );

  snp_tmo #(.TMO_CYCLES(TMO_CYCLES)) u_tmo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (line_s[1]),
    .tmo_o (timeout_o)
  );

  snp_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .evt_i        (evt),
    .sda_i        (line_s[0]),
    .tmo_i        (timeout_o),
    .host_addr_i  (host_addr_i),
    .snoop_addr_i (snoop_addr_i),
    .host_match_o (host_match_o),
    .snoop_match_o(snoop_match_o),
    .busy_o       (bus_busy_o)
  );
endmodule

// File: rtl/snp_checker.sv
module snp_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic host_match_o,
  input logic snoop_match_o,
  input logic bus_busy_o,
  input logic timeout_o
);
  AST_HOST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_match_o |=> !host_match_o);  // R3
  AST_SNOOP_PULSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_match_o |=> !snoop_match_o);  // R3
  AST_MATCH_IN_TRANSFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_match_o || snoop_match_o) |-> $past(bus_busy_o));  // R6
  AST_TMO_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);  // R5
  AST_TMO_DROPS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !bus_busy_o);  // R7
  AST_TMO_KILLS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !(host_match_o || snoop_match_o));  // R4
endmodule

bind smbus_snooper snp_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_match_o (host_match_o),
  .snoop_match_o(snoop_match_o),
  .bus_busy_o   (bus_busy_o),
  .timeout_o    (timeout_o)
);

// File: tb/smbus_snooper_test.sv
module smbus_snooper_test;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 8;
  localparam int TMO        = 200;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic [6:0] host_addr = 7'h2A, snoop_addr = 7'h51;
  logic       host_m, snoop_m, busy, tmo;

  int n_cmp = 0, n_bad = 0, tmo_seen = 0;
  bit done = 0;
  logic [1:0] exp_q[$];
  string      req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_snooper #(.TMO_CYCLES(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda),
    .host_addr_i(host_addr), .snoop_addr_i(snoop_addr),
    .host_match_o(host_m), .snoop_match_o(snoop_m),
    .bus_busy_o(busy), .timeout_o(tmo)
  );

  task automatic check(bit ok, string req, string act, string exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // Monitor: every match pulse pops one expected item
  always @(negedge clk) begin
    if (rst_n && tmo) tmo_seen++;
    if (rst_n && (host_m || snoop_m)) begin
      if (exp_q.size() == 0)
        check(0, "R3", $sformatf("h%0b s%0b", host_m, snoop_m), "no pulse");
      else begin
        logic [1:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check({host_m, snoop_m} == e, r,
              $sformatf("h%0b s%0b", host_m, snoop_m),
              $sformatf("h%0b s%0b", e[1], e[0]));
      end
    end
  end

  task automatic wait_h(int n = 1);
    repeat (n * H) @(negedge clk);
  endtask

  task automatic expect_match(logic [1:0] e, string r);
    exp_q.push_back(e);
    req_q.push_back(r);
  endtask

  task automatic bus_start();
    sda = 1'b1; wait_h(); scl = 1'b1; wait_h();
    sda = 1'b0; wait_h(); scl = 1'b0; wait_h();
  endtask

  task automatic bus_stop();
    sda = 1'b0; wait_h(); scl = 1'b1; wait_h(); sda = 1'b1; wait_h();
  endtask

  task automatic send_bit(logic b);
    sda = b; wait_h(); scl = 1'b1; wait_h(); scl = 1'b0; wait_h();
  endtask

  task automatic send_byte(logic [7:0] d);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    send_bit(1'b0);
  endtask

  task automatic settle(string r);
    wait_h(3);
    check(exp_q.size() == 0, r, $sformatf("%0d pending", exp_q.size()), "0 pending");
    exp_q.delete();
    req_q.delete();
  endtask

  task automatic xfer(logic [6:0] a, logic rw, logic [1:0] e, string r);
    bus_start();
    check(busy == 1'b1, "R6", $sformatf("%0b", busy), "1");
    send_byte({a, rw});
    send_byte(8'hC3);
    if (e != 2'b00) expect_match(e, r);
    check(exp_q.size() == (e != 2'b00 ? 1 : 0), "R3",
          "pulse before stop", "pulse held until stop");
    bus_stop();
    settle(r);
    check(busy == 1'b0, "R6", $sformatf("%0b", busy), "0");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({host_m, snoop_m, busy, tmo} == 4'b0, "R9", $sformatf("%b", {host_m, snoop_m, busy, tmo}), "0000");
    rst_n = 1'b1;
    wait_h(2);
    check({host_m, snoop_m, busy, tmo} == 4'b0, "R9", $sformatf("%b", {host_m, snoop_m, busy, tmo}), "0000");

    xfer(7'h2A, 1'b0, 2'b10, "R1");  // host write
    xfer(7'h2A, 1'b1, 2'b00, "R1");  // host read: ignored
    xfer(7'h51, 1'b1, 2'b01, "R2");  // snoop read
    xfer(7'h51, 1'b0, 2'b01, "R2");  // snoop write
    xfer(7'h33, 1'b0, 2'b00, "R1");  // no match
    snoop_addr = 7'h2A;
    xfer(7'h2A, 1'b0, 2'b11, "R2");
    snoop_addr = 7'h51;

    // R3: repeated start commits the first part
    bus_start();
    send_byte({7'h2A, 1'b0});
    send_byte(8'h5A);
    expect_match(2'b10, "R3");
    bus_start();
    settle("R3");
    send_byte({7'h10, 1'b1});
    send_byte(8'hFF);
    bus_stop();
    settle("R3");

    // R8: restart mid-byte realigns the address
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte({7'h51, 1'b1});
    expect_match(2'b01, "R8");
    bus_stop();
    settle("R8");

    // R10: stop mid-byte after the address acknowledge
    bus_start();
    send_byte({7'h2A, 1'b0});
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    settle("R10");

    // R4/R5/R7: timeout after the address matched
    tmo_seen = 0;
    bus_start();
    send_byte({7'h2A, 1'b0});
    sda = 1'b0;
    repeat (TMO + 20) @(negedge clk);
    check(tmo_seen == 1, "R5", $sformatf("%0d", tmo_seen), "1");
    check(busy == 1'b0, "R7", $sformatf("%0b", busy), "0");
    repeat (TMO) @(negedge clk);
    check(tmo_seen == 1, "R5", $sformatf("%0d", tmo_seen), "1");
    scl = 1'b1; wait_h(); sda = 1'b1; wait_h();
    settle("R4");
    scl = 1'b0; wait_h();
    send_byte({7'h2A, 1'b0});
    check(busy == 1'b0, "R7", $sformatf("%0b", busy), "0");
    bus_stop();
    settle("R7");

    xfer(7'h2A, 1'b0, 2'b10, "R7");  // recovers on next start

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule